// File: doc/BRIEF.md
# Real-Time Clock Register Port

This block is the host-side register file of a classic battery-clock style real-time clock. Software reaches it through two byte ports: an index port selects one of fourteen internal bytes, and a data port reads or writes the selected byte. Indices 0 to 9 hold the time and date bytes: seconds, minutes and hours with an alarm byte after each, then day-of-week, day-of-month, month and year. These bytes are loaded at reset from parameters. Indices 10 to 13 are status registers A to D. The block does not advance the calendar. It stores the bytes, models the status registers, and drives a periodic interrupt.

Reading status register A inverts its update-in-progress flag each time, so software that polls for that flag to change always sees it change. Writes that would select a time base, rate or mode the block does not support are refused. A refusal shows on a one-cycle reject pulse, and the target register keeps its old value. The periodic-interrupt enable in register B starts and stops an interval timer. While the timer runs, it emits a one-cycle interrupt pulse every `PERIOD_CYCLES` clocks.

Access state machine: `ACC_IDLE` shows no response. Any accepted write, or no request, goes to `ACC_IDLE`. A refused write goes to `ACC_REJECT`. A read with no write goes to `ACC_RDATA`. Both response states last exactly one cycle. Timer state machine: `TMR_IDLE` goes to `TMR_COUNT` when the enable is set. `TMR_COUNT` goes to `TMR_FIRE` when the count reaches zero. `TMR_FIRE` goes back to `TMR_COUNT` with the count reloaded. Both `TMR_COUNT` and `TMR_FIRE` drop to `TMR_IDLE` when the enable clears.

Top module: `rtc_reg_port`

## Requirements
- R1: A write to the index port (bus_port=0) with a value 0x00 to 0x0D is accepted. A value above 0x0D is rejected with a reject pulse, and the previous index stays selected.
- R2: Data-port writes to indices 0 to 9 are accepted, and a later read of the same index returns the written byte.
- R3: After reset the time bytes read as follows: index 0 = INIT_SEC, 2 = INIT_MIN, 4 = INIT_HOUR, 6 = INIT_WDAY0+1 (1 is Sunday), 7 = INIT_MDAY, 8 = INIT_MONTH0+1 (January is 1), 9 = year. The alarm bytes 1, 3 and 5 read 0x00.
- R4: With YEAR_BCD=1 the year byte is INIT_YEAR mod 100, with the tens digit in bits 7:4 and the units digit in bits 3:0. With YEAR_BCD=0 it is the low 8 bits of INIT_YEAR.
- R5: Register A (index 0x0A) resets to 0x26. Every read inverts bit 7 (update in progress) and returns the new value.
- R6: A write to register A is accepted only if the byte is exactly 0x26, and the write clears bit 7. Any other byte is rejected and register A is left unchanged.
- R7: Register B (index 0x0B) resets to 0x46. A write is accepted only if the byte, with bit 6 (periodic enable) and bit 3 (square-wave enable) masked off, equals 0x06 (bit 2 binary mode, bit 1 24-hour mode). Otherwise it is rejected and register B is unchanged.
- R8: Registers C and D (indices 0x0C, 0x0D) always read 0x00, and data writes to them are rejected.
- R9: While register B bit 6 is set, irq_pulse is high for exactly one cycle every PERIOD_CYCLES cycles.
- R10: Once an accepted write clears bit 6, no pulse appears from the second cycle after the write onward. If an accepted write sets bit 6 while the timer is idle, the first pulse appears PERIOD_CYCLES cycles after the write's clock edge.
- R11: A read (bus_rd high, bus_wr low) returns bus_rvalid and bus_rdata in the cycle after the request. When bus_wr and bus_rd are high together, the write is performed and the read is ignored (no bus_rvalid). bus_rvalid and bus_reject are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe for the data port |
| bus_port | input | 1 | Write target: 0 selects the index port, 1 the data port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | One-cycle read response |
| bus_reject | output | 1 | One-cycle pulse for a refused write |
| irq_pulse | output | 1 | One-cycle periodic interrupt |

## Verification
The bench builds the block with PERIOD_CYCLES=8, so pulse spacing, the silence after disabling and the first pulse after re-enabling can all be measured exactly within a few dozen cycles. The preload is seconds 30, minutes 45, hour 13, weekday index 3, day 17, month index 5 and year 124. A second instance shares the same bus with YEAR_BCD=0, so a single year read checks the BCD year (0x24) and the binary year (0x7C) side by side.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int BYTE_W     = 8;
    localparam int TIME_BYTES = 10;
    localparam int LAST_INDEX = 13;
    localparam int IDX_W      = $clog2(LAST_INDEX + 1);

    localparam logic [IDX_W-1:0] IDX_STAT_A = IDX_W'(10);
    localparam logic [IDX_W-1:0] IDX_STAT_B = IDX_W'(11);
    localparam logic [IDX_W-1:0] IDX_STAT_C = IDX_W'(12);
    localparam logic [IDX_W-1:0] IDX_STAT_D = IDX_W'(13);

    // status register A: bit 7 update flag, divider/rate reset pattern
    localparam logic [BYTE_W-1:0] A_UPDATE_FLAG = 8'h80;
    localparam logic [BYTE_W-1:0] A_RESET       = 8'h26;

    // status register B bits
    localparam logic [BYTE_W-1:0] B_PERIODIC_EN = 8'h40;
    localparam logic [BYTE_W-1:0] B_SQUARE_EN   = 8'h08;
    localparam logic [BYTE_W-1:0] B_BINARY      = 8'h04;
    localparam logic [BYTE_W-1:0] B_HOUR24      = 8'h02;
    localparam logic [BYTE_W-1:0] B_FREE_MASK   = B_PERIODIC_EN | B_SQUARE_EN;
    localparam logic [BYTE_W-1:0] B_FIXED       = B_BINARY | B_HOUR24;
    localparam logic [BYTE_W-1:0] B_RESET       = B_PERIODIC_EN | B_FIXED;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_RDATA,
        ACC_REJECT
    } acc_state_t;

    typedef enum logic [1:0] {
        TMR_IDLE,
        TMR_COUNT,
        TMR_FIRE
    } tmr_state_t;

    function automatic logic [BYTE_W-1:0] year_byte(input int years, input bit bcd);
        int two_digit;
        if (bcd) begin
            two_digit = years % 100;
            return BYTE_W'(((two_digit / 10) << 4) + (two_digit % 10));
        end
        return BYTE_W'(years);
    endfunction

    // time/date byte layout is fixed because software decodes these indices
    function automatic logic [BYTE_W-1:0] preload_byte(
        input int idx, input int years, input bit bcd, input int month0,
        input int mday, input int hour, input int minute, input int sec,
        input int wday0);
        case (idx)
            0:       return BYTE_W'(sec);
            2:       return BYTE_W'(minute);
            4:       return BYTE_W'(hour);
            6:       return BYTE_W'(wday0 + 1);
            7:       return BYTE_W'(mday);
            8:       return BYTE_W'(month0 + 1);
            9:       return year_byte(years, bcd);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/rtc_periodic_timer.sv
module rtc_periodic_timer
    import rtc_pkg::*;
#(
    parameter int PERIOD_CYCLES = 195313
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic irq_pulse
);

    localparam int CNT_W = (PERIOD_CYCLES > 2) ? $clog2(PERIOD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PERIOD_CYCLES - 2);

    tmr_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state: COUNT spans PERIOD-1 cycles, FIRE one cycle
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TMR_IDLE: begin
                if (enable) begin
                    state_d = TMR_COUNT;
                    cnt_d   = RELOAD;
                end
            end
            TMR_COUNT: begin
                if (!enable) begin
                    state_d = TMR_IDLE;
                end else if (cnt_q == '0) begin
                    state_d = TMR_FIRE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            TMR_FIRE: begin
                if (!enable) begin
                    state_d = TMR_IDLE;
                end else begin
                    state_d = TMR_COUNT;
                    cnt_d   = RELOAD;
                end
            end
            default: state_d = TMR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq_pulse = (state_q == TMR_FIRE);
    end

    // R9: pulse never lasts two cycles
    a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R9: countdown never exceeds reload value
    a_r9_reload_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_COUNT) |-> (cnt_q <= RELOAD));

    // R10: enable low for two samples means silence
    a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !$past(enable)) |-> !irq_pulse);

    // R10: dropping enable parks the timer
    a_r10_idle_after_off: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(enable) |=> (state_q == TMR_IDLE));

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter bit YEAR_BCD    = 1'b1,
    parameter int INIT_YEAR   = 124,
    parameter int INIT_MONTH0 = 0,
    parameter int INIT_MDAY   = 1,
    parameter int INIT_HOUR   = 0,
    parameter int INIT_MIN    = 0,
    parameter int INIT_SEC    = 0,
    parameter int INIT_WDAY0  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_we,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              wr_reject,
    output logic              periodic_en
);

    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] time_q [TIME_BYTES];
    logic [BYTE_W-1:0] stat_a_q;
    logic [BYTE_W-1:0] stat_b_q;

    logic idx_is_time;
    logic idx_bad;
    logic data_bad;

    always_comb begin
        idx_is_time = (idx_q < IDX_W'(TIME_BYTES));
        idx_bad     = (wdata > BYTE_W'(LAST_INDEX));
        data_bad    = 1'b0;
        if (!idx_is_time) begin
            unique case (idx_q)
                IDX_STAT_A: data_bad = (wdata != A_RESET);
                IDX_STAT_B: data_bad = ((wdata & ~B_FREE_MASK) != B_FIXED);
                default:    data_bad = 1'b1;
            endcase
        end
        wr_reject = (idx_we && idx_bad) || (data_we && data_bad);
    end

    // read value, register A shows its post-toggle value
    always_comb begin
        rd_byte = '0;
        if (idx_is_time) begin
            rd_byte = time_q[idx_q];
        end else if (idx_q == IDX_STAT_A) begin
            rd_byte = stat_a_q ^ A_UPDATE_FLAG;
        end else if (idx_q == IDX_STAT_B) begin
            rd_byte = stat_b_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (idx_we && !idx_bad) begin
            idx_q <= IDX_W'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TIME_BYTES; i++) begin
                time_q[i] <= preload_byte(i, INIT_YEAR, YEAR_BCD, INIT_MONTH0,
                                          INIT_MDAY, INIT_HOUR, INIT_MIN,
                                          INIT_SEC, INIT_WDAY0);
            end
        end else if (data_we && idx_is_time) begin
            time_q[idx_q] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_a_q <= A_RESET;
        end else if (data_we && !data_bad && idx_q == IDX_STAT_A) begin
            stat_a_q <= wdata;
        end else if (data_re && idx_q == IDX_STAT_A) begin
            stat_a_q <= stat_a_q ^ A_UPDATE_FLAG;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_b_q <= B_RESET;
        end else if (data_we && !data_bad && idx_q == IDX_STAT_B) begin
            stat_b_q <= wdata;
        end
    end

    assign periodic_en = |(stat_b_q & B_PERIODIC_EN);

    // R1: selected index never leaves the implemented range
    a_r1_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_W'(LAST_INDEX));

    // R5: each read of register A flips the update flag
    a_r5_flag_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (data_re && !data_we && idx_q == IDX_STAT_A)
        |=> (stat_a_q[7] != $past(stat_a_q[7])));

    // R6: divider and rate bits of register A never change
    a_r6_rate_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        stat_a_q[6:0] == A_RESET[6:0]);

    // R7: register B keeps its mandatory mode bits
    a_r7_mode_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_b_q & ~B_FREE_MASK) == B_FIXED);

endmodule

// File: rtl/rtc_reg_port.sv
module rtc_reg_port
    import rtc_pkg::*;
#(
    parameter int PERIOD_CYCLES = 195313,
    parameter bit YEAR_BCD      = 1'b1,
    parameter int INIT_YEAR     = 124,
    parameter int INIT_MONTH0   = 0,
    parameter int INIT_MDAY     = 1,
    parameter int INIT_HOUR     = 0,
    parameter int INIT_MIN      = 0,
    parameter int INIT_SEC      = 0,
    parameter int INIT_WDAY0    = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_port,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       bus_rvalid,
    output logic       bus_reject,
    output logic       irq_pulse
);

    acc_state_t state_q, state_d;
    logic [BYTE_W-1:0] rdata_q;
    logic [BYTE_W-1:0] rd_byte;
    logic idx_we, data_we, data_re;
    logic wr_reject;
    logic periodic_en;

    // write wins over read in the same cycle
    always_comb begin
        idx_we  = bus_wr && !bus_port;
        data_we = bus_wr && bus_port;
        data_re = bus_rd && !bus_wr;
    end

    rtc_regfile #(
        .YEAR_BCD    (YEAR_BCD),
        .INIT_YEAR   (INIT_YEAR),
        .INIT_MONTH0 (INIT_MONTH0),
        .INIT_MDAY   (INIT_MDAY),
        .INIT_HOUR   (INIT_HOUR),
        .INIT_MIN    (INIT_MIN),
        .INIT_SEC    (INIT_SEC),
        .INIT_WDAY0  (INIT_WDAY0)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .idx_we      (idx_we),
        .data_we     (data_we),
        .data_re     (data_re),
        .wdata       (bus_wdata),
        .rd_byte     (rd_byte),
        .wr_reject   (wr_reject),
        .periodic_en (periodic_en)
    );

    rtc_periodic_timer #(
        .PERIOD_CYCLES (PERIOD_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (periodic_en),
        .irq_pulse (irq_pulse)
    );

    // next response state
    always_comb begin
        state_d = ACC_IDLE;
        unique case (state_q)
            ACC_IDLE, ACC_RDATA, ACC_REJECT: begin
                if (bus_wr) begin
                    state_d = wr_reject ? ACC_REJECT : ACC_IDLE;
                end else if (bus_rd) begin
                    state_d = ACC_RDATA;
                end
            end
            default: state_d = ACC_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (data_re) begin
                rdata_q <= rd_byte;
            end
        end
    end

    // outputs
    always_comb begin
        bus_rvalid = (state_q == ACC_RDATA);
        bus_reject = (state_q == ACC_REJECT);
        bus_rdata  = bus_rvalid ? rdata_q : '0;
    end

    // R11: at most one response kind per cycle
    a_r11_resp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_rvalid, bus_reject}));

    // R11: a response follows a lone read request
    a_r11_rvalid_origin: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_rd && !bus_wr));

    // R11: a reject follows a write
    a_r11_reject_origin: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reject |-> $past(bus_wr));

endmodule

// File: tb/tb_rtc_reg_port.sv
module tb_rtc_reg_port;

    localparam int P = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0, bus_port = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, bus_rdata_b;
    logic bus_rvalid, bus_reject, irq_pulse;
    logic bus_rvalid_b, bus_reject_b, irq_pulse_b;

    always #2.5 clk = ~clk;

    rtc_reg_port #(
        .PERIOD_CYCLES(P), .YEAR_BCD(1'b1), .INIT_YEAR(124), .INIT_MONTH0(5),
        .INIT_MDAY(17), .INIT_HOUR(13), .INIT_MIN(45), .INIT_SEC(30), .INIT_WDAY0(3)
    ) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .bus_reject(bus_reject), .irq_pulse(irq_pulse)
    );

    rtc_reg_port #(
        .PERIOD_CYCLES(P), .YEAR_BCD(1'b0), .INIT_YEAR(124), .INIT_MONTH0(5),
        .INIT_MDAY(17), .INIT_HOUR(13), .INIT_MIN(45), .INIT_SEC(30), .INIT_WDAY0(3)
    ) dut_bin (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata_b),
        .bus_rvalid(bus_rvalid_b), .bus_reject(bus_reject_b), .irq_pulse(irq_pulse_b)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_wr_cyc = 0;

    // scoreboard queues: kind 0 write, 1 read, 2 write+read
    int         q_kind [$];
    logic       q_rej  [$];
    logic [7:0] q_exp  [$];
    logic       q_chkb [$];
    logic [7:0] q_expb [$];
    string      q_tag  [$];

    int  pulse_cnt = 0;
    int  last_pulse = 0;
    bit  have_last = 1'b0;
    bit  spacing_on = 1'b1;
    bit  uip = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // monitor: pops one expectation per completed request
    always @(negedge clk) begin
        if (q_kind.size() > 0) begin
            int k; logic r; logic [7:0] e; logic cb; logic [7:0] eb; string t;
            k = q_kind.pop_front(); r = q_rej.pop_front(); e = q_exp.pop_front();
            cb = q_chkb.pop_front(); eb = q_expb.pop_front(); t = q_tag.pop_front();
            if (k == 1) begin
                check(bus_rvalid && !bus_reject && bus_rdata == e, t,
                      {bus_rvalid, bus_reject, bus_rdata}, {2'b10, e});
                if (cb) check(bus_rvalid_b && bus_rdata_b == eb, t,
                              {bus_rvalid_b, bus_rdata_b}, {1'b1, eb});
            end else begin
                check(!bus_rvalid && bus_reject == r, t,
                      {bus_rvalid, bus_reject}, {1'b0, r});
            end
        end
    end

    // interrupt monitor
    always @(negedge clk) begin
        if (rst_n && irq_pulse) begin
            pulse_cnt++;
            if (spacing_on && have_last)
                check(cyc - last_pulse == P, "R9", cyc - last_pulse, P);
            last_pulse = cyc;
            have_last = 1'b1;
        end
    end

    task automatic op(input bit wr, input bit rd, input bit port, input logic [7:0] d,
                      input bit rej, input logic [7:0] e, input bit cb,
                      input logic [7:0] eb, input string tag);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_port = port; bus_wdata = d;
        @(posedge clk);
        #1;
        last_wr_cyc = cyc;
        q_kind.push_back(wr ? (rd ? 2 : 0) : 1);
        q_rej.push_back(rej); q_exp.push_back(e); q_chkb.push_back(cb);
        q_expb.push_back(eb); q_tag.push_back(tag);
        bus_wr = 0; bus_rd = 0;
    endtask

    task automatic set_index(input logic [7:0] i, input bit rej, input string tag);
        op(1, 0, 0, i, rej, 8'h00, 0, 8'h00, tag);
    endtask
    task automatic wr_data(input logic [7:0] d, input bit rej, input string tag);
        op(1, 0, 1, d, rej, 8'h00, 0, 8'h00, tag);
    endtask
    task automatic rd_data(input logic [7:0] e, input string tag);
        op(0, 1, 0, 8'h00, 0, e, 0, 8'h00, tag);
    endtask
    task automatic rd_a(input string tag);
        uip = ~uip;
        rd_data(uip ? 8'hA6 : 8'h26, tag);
    endtask
    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        int n0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11: idle outputs after reset
        check(!bus_rvalid && !bus_reject, "R11", {bus_rvalid, bus_reject}, 0);

        // R9: pulses run from reset since register B enables them
        idle(3 * P + 2);
        check(pulse_cnt >= 2, "R9", pulse_cnt, 2);

        // R3: preloaded time bytes
        rd_data(8'd30, "R3");
        set_index(8'd1, 0, "R1"); rd_data(8'h00, "R3");
        set_index(8'd2, 0, "R1"); rd_data(8'd45, "R3");
        set_index(8'd4, 0, "R1"); rd_data(8'd13, "R3");
        set_index(8'd6, 0, "R1"); rd_data(8'd4,  "R3");
        set_index(8'd7, 0, "R1"); rd_data(8'd17, "R3");
        set_index(8'd8, 0, "R1"); rd_data(8'd6,  "R3");
        // R4: BCD year on dut, binary year on dut_bin
        set_index(8'd9, 0, "R1");
        op(0, 1, 0, 8'h00, 0, 8'h24, 1, 8'h7C, "R4");

        // R2: write/read patterns
        wr_data(8'hA5, 0, "R2"); rd_data(8'hA5, "R2");
        set_index(8'd0, 0, "R1"); wr_data(8'h00, 0, "R2"); rd_data(8'h00, "R2");
        set_index(8'd5, 0, "R1"); wr_data(8'hFF, 0, "R2"); rd_data(8'hFF, "R2");
        wr_data(8'h5A, 0, "R2"); rd_data(8'h5A, "R2");

        // R1: out-of-range index rejected, index kept at 5
        set_index(8'h0E, 1, "R1"); rd_data(8'h5A, "R1");
        set_index(8'hFF, 1, "R1"); rd_data(8'h5A, "R1");

        // R8: registers C and D
        set_index(8'h0D, 0, "R1"); rd_data(8'h00, "R8");
        wr_data(8'h00, 1, "R8"); rd_data(8'h00, "R8");
        set_index(8'h0C, 0, "R1"); rd_data(8'h00, "R8");
        wr_data(8'h80, 1, "R8"); rd_data(8'h00, "R8");

        // R5: update flag toggles on every read
        set_index(8'h0A, 0, "R1");
        rd_a("R5"); rd_a("R5"); rd_a("R5");
        // R6: only the reset byte is accepted, and it clears the flag
        wr_data(8'h27, 1, "R6"); rd_a("R6");
        wr_data(8'hA6, 1, "R6"); rd_a("R6");
        wr_data(8'h26, 0, "R6"); uip = 1'b0; rd_a("R6");

        // R7: register B acceptance rule
        set_index(8'h0B, 0, "R1"); rd_data(8'h46, "R7");
        wr_data(8'h16, 1, "R7"); rd_data(8'h46, "R7");
        wr_data(8'h04, 1, "R7"); rd_data(8'h46, "R7");
        wr_data(8'h4E, 0, "R7"); rd_data(8'h4E, "R7");

        // R10: disabling stops the pulses
        spacing_on = 1'b0;
        wr_data(8'h0E, 0, "R7");
        idle(1);
        n0 = pulse_cnt;
        idle(4 * P);
        check(pulse_cnt == n0, "R10", pulse_cnt, n0);
        rd_data(8'h0E, "R7");

        // R10: re-enabling, first pulse P cycles after the write edge
        wr_data(8'h46, 0, "R7");
        n0 = last_wr_cyc;
        begin
            int pc;
            pc = pulse_cnt;
            for (int i = 0; i < 3 * P && pulse_cnt == pc; i++) idle(1);
            check(pulse_cnt > pc, "R10", pulse_cnt, pc + 1);
        end
        check(last_pulse - n0 == P, "R10", last_pulse - n0, P);
        spacing_on = 1'b1;
        idle(3 * P);

        // R11: write and read together, write wins
        set_index(8'd1, 0, "R1");
        op(1, 1, 1, 8'h3C, 0, 8'h00, 0, 8'h00, "R11");
        rd_data(8'h3C, "R11");

        idle(3);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule